// File: doc/BRIEF.md
# Prescaled Reloadable Down-Timer

An 8-bit timer that counts down from a value written by software. Its count events come from one of two sources: every cycle of the block clock, or one chosen edge of an external pin. An external pin edge is only seen after two synchronising flops. A power-of-two prescaler sits between the event source and the counter. One control bit decides which side owns that prescaler. When the timer owns it, the ratio runs from 2 to 256. When the watchdog owns it, the prescaler divides a watchdog base tick by 1 to 128, and the timer then steps once per event.

Each time a decrement lands the counter on zero, a sticky overflow flag is set. The counter then wraps to 0xFF and keeps going. Software clears the flag by writing 0 to it. The flag, gated by an active-low mask bit, drives the interrupt request. The CPU reads the counter and the control byte directly.

As an example of sizing, a reload of 64 with the 256 ratio on a 16384 Hz cycle clock gives one overflow per second.

Top module: `ptimer_top`

## Requirements
- R1: While reset is held, the counter reads 0xFF, the control byte reads 0x40 (interrupt masked, internal source, prescaler owned by the timer, ratio field 0), the overflow flag is 0 and the request is low.
- R2: With control bit 1 = 0 and control bit 2 = 0, the counter decrements once every 2^(n+1) clock cycles, where n is the ratio field in control bits 5:3.
- R3: With control bit 1 = 1, a count event is a rising pin transition when control bit 0 = 0, and a falling one when it is 1. The transition changes the counter on the third rising clock edge after the pin changes. The opposite edge has no effect.
- R4: With control bit 2 = 1, the counter decrements once per event, and `wdt_tick_o` pulses on every 2^n-th high cycle of `wdt_base_i`. With control bit 2 = 0, `wdt_tick_o` equals `wdt_base_i`.
- R5: A decrement from 1 to 0 sets the flag (control bit 7). The next decrement takes the counter from 0 to 0xFF.
- R6: A control write with bit 7 = 0 clears the flag. A write with bit 7 = 1 leaves the flag unchanged. A flag set in the same cycle as a clear wins.
- R7: `irq_o` is high exactly when the flag is 1 and control bit 6 is 0.
- R8: A data write (`wr_sel_i` = 0) loads the counter on the next clock edge and overrides a decrement in the same cycle. Loading 0 does not set the flag.
- R9: Every control write (`wr_sel_i` = 1) restarts the prescaler phase from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also the internal count source |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0 selects the data (counter) register, 1 the control register |
| wr_data_i | input | 8 | Write data |
| ext_pin_i | input | 1 | External count pin, asynchronous |
| wdt_base_i | input | 1 | Watchdog base tick, one cycle per pulse |
| count_o | output | 8 | Current counter value |
| ctrl_o | output | 8 | Control byte including the overflow flag in bit 7 |
| irq_o | output | 1 | Timer interrupt request |
| wdt_tick_o | output | 1 | Tick delivered to the watchdog |

## Verification
On every cycle, the assertions check several properties. A decrement lowers the counter by exactly one, and a zero count wraps to 0xFF. A load takes the written value. The prescaler only fires on an event and restarts after a control write. The flag only falls after a clearing write, and only rises with the counter at zero. Selected pin edges never come back to back. The request only rises with the flag or with an unmask. Some properties rest on counting across many cycles, and only the bench scenarios can show them: the actual division ratios, the three-cycle pin latency, ignoring the unselected edge, the phase reset, and the watchdog-side ratio.

// File: rtl/ptimer_pkg.sv
package ptimer_pkg;

  localparam int BYTE_W  = 8;
  localparam int RATIO_W = 3;

  // Control byte layout, most significant bit first
  typedef struct packed {
    logic               flag;        // bit 7: overflow flag
    logic               irq_mask;    // bit 6: 1 masks the request
    logic [RATIO_W-1:0] ratio;       // bits 5:3: prescale exponent
    logic               pre_to_wdt;  // bit 2: prescaler owned by watchdog
    logic               ext_src;     // bit 1: count external pin edges
    logic               fall_edge;   // bit 0: count falling pin edges
  } tctl_t;

  localparam tctl_t CTL_RESET = tctl_t'(8'h40);

  // Mask of low prescaler bits that must all be set for a tick.
  // The timer gets one extra doubling compared to the watchdog.
  function automatic logic [BYTE_W-1:0] pre_mask(input logic [RATIO_W-1:0] ratio,
                                                 input logic for_timer);
    logic [BYTE_W:0] span;
    span = (BYTE_W+1)'(1) << (int'(ratio) + int'(for_timer));
    return BYTE_W'(span - (BYTE_W+1)'(1));
  endfunction

endpackage

// File: rtl/ptimer_edge.sv
module ptimer_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic fall_sel_i,
  output logic edge_o
);
  localparam int TOP = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              rise_w;
  logic              fall_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      prev_q <= sync_q[TOP];
    end
  end

  assign rise_w = sync_q[TOP] & ~prev_q;
  assign fall_w = ~sync_q[TOP] & prev_q;
  assign edge_o = fall_sel_i ? fall_w : rise_w;

  // R3
  rise_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_w |=> !rise_w);

  // R3
  fall_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_w |=> !fall_w);

endmodule

// File: rtl/ptimer_prescaler.sv
module ptimer_prescaler #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         ev_i,
  input  logic [W-1:0] mask_i,
  output logic         tick_o
);
  logic [W-1:0] phase_q;
  logic         match_w;

  assign match_w = ((phase_q & mask_i) == mask_i);
  assign tick_o  = ev_i & match_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     phase_q <= '0;
    else if (clr_i) phase_q <= '0;
    else if (ev_i)  phase_q <= phase_q + W'(1);
  end

  // R2
  tick_needs_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> ev_i);

  // R9
  phase_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (phase_q == '0));

endmodule

// File: rtl/ptimer_counter.sv
module ptimer_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o,
  output logic         zero_hit_o
);
  logic [W-1:0] cnt_q;
  logic         step_w;

  assign step_w     = dec_i & ~ld_i;
  assign zero_hit_o = step_w & (cnt_q == W'(1));
  assign cnt_o      = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '1;
    else if (ld_i)   cnt_q <= ld_val_i;
    else if (dec_i)  cnt_q <= cnt_q - W'(1);
  end

  // R8
  load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_i |=> (cnt_q == $past(ld_val_i)));

  // R2
  step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && !ld_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - W'(1)));

  // R5
  wrap_to_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && !ld_i && cnt_q == '0) |=> (cnt_q == '1));

endmodule

// File: rtl/ptimer_top.sv
module ptimer_top
  import ptimer_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              ext_pin_i,
  input  logic              wdt_base_i,
  output logic [BYTE_W-1:0] count_o,
  output logic [BYTE_W-1:0] ctrl_o,
  output logic              irq_o,
  output logic              wdt_tick_o
);
  tctl_t             ctl_q;
  logic              ctl_wr_w;
  logic              dat_wr_w;
  logic              pin_edge_w;
  logic              src_ev_w;
  logic              pre_ev_w;
  logic              pre_tick_w;
  logic              tmr_tick_w;
  logic              zero_hit_w;
  logic              flag_clr_w;
  logic [BYTE_W-1:0] mask_w;

  assign ctl_wr_w = wr_en_i &  wr_sel_i;
  assign dat_wr_w = wr_en_i & ~wr_sel_i;

  ptimer_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_i      (ext_pin_i),
    .fall_sel_i (ctl_q.fall_edge),
    .edge_o     (pin_edge_w)
  );

  // Event source: one per clock, or one per selected pin edge
  assign src_ev_w = ctl_q.ext_src ? pin_edge_w : 1'b1;

  // Prescaler input follows its owner
  assign pre_ev_w = ctl_q.pre_to_wdt ? wdt_base_i : src_ev_w;
  assign mask_w   = pre_mask(ctl_q.ratio, ~ctl_q.pre_to_wdt);

  ptimer_prescaler #(.W(BYTE_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (ctl_wr_w),
    .ev_i   (pre_ev_w),
    .mask_i (mask_w),
    .tick_o (pre_tick_w)
  );

  assign tmr_tick_w = ctl_q.pre_to_wdt ? src_ev_w   : pre_tick_w;
  assign wdt_tick_o = ctl_q.pre_to_wdt ? pre_tick_w : wdt_base_i;

  ptimer_counter #(.W(BYTE_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld_i       (dat_wr_w),
    .ld_val_i   (wr_data_i),
    .dec_i      (tmr_tick_w),
    .cnt_o      (count_o),
    .zero_hit_o (zero_hit_w)
  );

  assign flag_clr_w = ctl_wr_w & ~wr_data_i[BYTE_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= CTL_RESET;
    end else begin
      if (ctl_wr_w) begin
        ctl_q.irq_mask   <= wr_data_i[6];
        ctl_q.ratio      <= wr_data_i[5:3];
        ctl_q.pre_to_wdt <= wr_data_i[2];
        ctl_q.ext_src    <= wr_data_i[1];
        ctl_q.fall_edge  <= wr_data_i[0];
      end
      // Hardware set outranks a software clear
      ctl_q.flag <= zero_hit_w | (ctl_q.flag & ~flag_clr_w);
    end
  end

  assign ctrl_o = ctl_q;
  assign irq_o  = ctl_q.flag & ~ctl_q.irq_mask;

  // R6
  flag_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl_q.flag) |-> $past(ctl_wr_w && !wr_data_i[BYTE_W-1]));

  // R5
  flag_rise_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_q.flag) |-> (count_o == '0));

  // R7
  irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ($rose(ctl_q.flag) || $fell(ctl_q.irq_mask)));

  // R4
  wdt_owner_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.pre_to_wdt && !ctl_q.ext_src && !dat_wr_w) |=> (count_o == $past(count_o) - BYTE_W'(1)));

endmodule

// File: tb/test_ptimer_top.sv
module test_ptimer_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en_i = 1'b0;
  logic       wr_sel_i = 1'b0;
  logic [7:0] wr_data_i = 8'h00;
  logic       ext_pin_i = 1'b0;
  logic       wdt_base_i = 1'b0;
  logic [7:0] count_o;
  logic [7:0] ctrl_o;
  logic       irq_o;
  logic       wdt_tick_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  ptimer_top i_ptimer_top (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en_i    (wr_en_i),
    .wr_sel_i   (wr_sel_i),
    .wr_data_i  (wr_data_i),
    .ext_pin_i  (ext_pin_i),
    .wdt_base_i (wdt_base_i),
    .count_o    (count_o),
    .ctrl_o     (ctrl_o),
    .irq_o      (irq_o),
    .wdt_tick_o (wdt_tick_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference state
  int   m_cnt  = 255;
  int   m_ctl  = 64;
  int   m_pre  = 0;
  bit   m_flag = 1'b0;
  bit   pin_hist [3] = '{0, 0, 0};  // newest sample first

  function automatic int div_now();
    int owner_bonus;
    owner_bonus = ((m_ctl >> 2) & 1) ? 0 : 1;
    return 1 << (((m_ctl >> 3) & 7) + owner_bonus);
  endfunction

  function automatic bit pre_fires(bit ev);
    return ev && ((m_pre % div_now()) == div_now() - 1);
  endfunction

  function automatic bit exp_wdt();
    if ((m_ctl >> 2) & 1) return pre_fires(wdt_base_i);
    return wdt_base_i;
  endfunction

  always @(posedge clk) begin
    bit seen_edge, src, pre_in, tick, cwr, dwr;
    cycles++;
    if (!rst_n) begin
      m_cnt = 255; m_ctl = 64; m_pre = 0; m_flag = 0;
      pin_hist = '{0, 0, 0};
    end else begin
      if (m_ctl & 1) seen_edge = !pin_hist[1] && pin_hist[2];
      else           seen_edge = pin_hist[1] && !pin_hist[2];
      src    = ((m_ctl >> 1) & 1) ? seen_edge : 1'b1;
      pre_in = ((m_ctl >> 2) & 1) ? wdt_base_i : src;
      tick   = ((m_ctl >> 2) & 1) ? src : pre_fires(src);
      cwr    = wr_en_i && wr_sel_i;
      dwr    = wr_en_i && !wr_sel_i;
      if (cwr && !wr_data_i[7]) m_flag = 0;
      if (tick && !dwr && m_cnt == 1) m_flag = 1;
      if (dwr)       m_cnt = int'(wr_data_i);
      else if (tick) m_cnt = (m_cnt + 255) % 256;
      if (cwr)         m_pre = 0;
      else if (pre_in) m_pre = (m_pre + 1) % 256;
      if (cwr) m_ctl = int'(wr_data_i) & 127;
      pin_hist[2] = pin_hist[1];
      pin_hist[1] = pin_hist[0];
      pin_hist[0] = ext_pin_i;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the reference, at the falling edge
  task automatic cyc();
    @(negedge clk);
    chk("R2 count vs model", int'(count_o), m_cnt);
    chk("R6 ctrl vs model", int'(ctrl_o), (m_flag ? 128 : 0) + m_ctl);
    chk("R7 irq vs model", int'(irq_o), int'(m_flag && !((m_ctl >> 6) & 1)));
    chk("R4 wdt tick vs model", int'(wdt_tick_o), int'(exp_wdt()));
  endtask

  task automatic wr(input bit sel, input logic [7:0] d);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
    cyc();
    wr_en_i = 1'b0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    int ticks;
    run(3);
    // R1 reset values
    chk("R1 count reset", int'(count_o), 8'hFF);
    chk("R1 ctrl reset", int'(ctrl_o), 8'h40);
    chk("R1 irq reset", int'(irq_o), 0);
    rst_n = 1'b1;
    run(4);

    // R2: internal source, ratio 1 -> divide by 4
    wr(1'b1, 8'h08);
    wr(1'b0, 8'd10);
    run(3);
    chk("R2 first step after 4 cycles", int'(count_o), 9);
    run(3);
    chk("R2 no step before period", int'(count_o), 9);
    run(1);
    chk("R2 second step", int'(count_o), 8);

    // R5: divide by 2, unmasked, reach zero then wrap
    wr(1'b1, 8'h00);
    wr(1'b0, 8'd2);
    run(3);
    chk("R5 count at zero", int'(count_o), 0);
    chk("R5 flag set", int'(ctrl_o[7]), 1);
    chk("R7 irq with flag unmasked", int'(irq_o), 1);
    run(2);
    chk("R5 wrap to FF", int'(count_o), 8'hFF);

    // R7 mask, R6 clear rules
    wr(1'b1, 8'hC0);
    chk("R7 masked irq low", int'(irq_o), 0);
    chk("R6 flag kept by writing 1", int'(ctrl_o), 8'hC0);
    wr(1'b1, 8'h80);
    chk("R7 unmask raises irq", int'(irq_o), 1);
    wr(1'b1, 8'h00);
    chk("R6 flag cleared by writing 0", int'(ctrl_o), 8'h00);
    chk("R6 irq drops after clear", int'(irq_o), 0);

    // R8: load zero does not set flag
    wr(1'b0, 8'h00);
    chk("R8 loaded zero", int'(count_o), 0);
    run(3);
    chk("R8 no flag from loaded zero", int'(ctrl_o[7]), 0);

    // R3: external rising edges, one event per edge
    wr(1'b1, 8'h06);
    wr(1'b0, 8'd5);
    run(4);
    ext_pin_i = 1'b1;
    run(2);
    chk("R3 no step before sync", int'(count_o), 5);
    run(1);
    chk("R3 rising edge counted", int'(count_o), 4);
    ext_pin_i = 1'b0;
    run(5);
    chk("R3 falling edge ignored", int'(count_o), 4);
    wr(1'b1, 8'h07);
    run(2);
    ext_pin_i = 1'b1;
    run(5);
    chk("R3 rising ignored in fall mode", int'(count_o), 4);
    ext_pin_i = 1'b0;
    run(2);
    chk("R3 fall not yet counted", int'(count_o), 4);
    run(1);
    chk("R3 falling edge counted", int'(count_o), 3);

    // R4: watchdog ownership
    wr(1'b1, 8'h00);
    wdt_base_i = 1'b1;
    run(1);
    chk("R4 mirror base high", int'(wdt_tick_o), 1);
    wdt_base_i = 1'b0;
    run(1);
    chk("R4 mirror base low", int'(wdt_tick_o), 0);
    wdt_base_i = 1'b1;
    wr(1'b1, 8'h14);
    wr(1'b0, 8'd100);
    ticks = 0;
    for (int i = 0; i < 16; i++) begin
      cyc();
      if (wdt_tick_o) ticks++;
    end
    chk("R4 watchdog divide by 4", ticks, 4);
    chk("R4 timer steps every event", int'(count_o), 84);
    wdt_base_i = 1'b0;

    // R9: control write restarts the prescaler phase
    wr(1'b1, 8'h38);
    wr(1'b0, 8'd50);
    run(200);
    wr(1'b1, 8'h38);
    run(255);
    chk("R9 phase restarted, no step yet", int'(count_o), 50);
    run(1);
    chk("R9 step after full 256", int'(count_o), 49);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    if (cycles > WATCHDOG) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule